// File: doc/BRIEF.md
# Expansion Slot Address Relocator

This block sits between a 32-bit host expansion bus and an add-in card whose own address decoder only answers as slot $E. A static configuration input chooses the slot number, from $9 to $E, at which the card is to appear on the host. The block watches the host address, the function codes and the address strobe. For an access to the chosen slot it asserts a card select and hands the card a copy of the address in which the slot digit reads $E.

Two address forms are decoded, and /FC3 chooses between them. The 24-bit minor window carries the slot digit on A23–A20. The 32-bit standard window requires A31–A28 = $F and carries the slot digit on A27–A24. Only the active slot nibble is rewritten, by XOR with (slot XOR $E). When the card takes the bus, shown by /BGACK going low, the same XOR is applied to the card's address toward the host. The two address output enables then change over with a dead cycle between them. The card's interrupt request is steered onto the host slot interrupt line of the chosen slot.

Top module: `slot_relocator`

## Requirements
- R1: While rst_ni is low: card_sel_no is 1, both output enables are 0, every slot_irq_no bit is 1, and the effective slot is $E.
- R2: slot_sel_i values $9..$E become the effective slot one clock later. Any other value gives an effective slot of $E, which is pass-through with no rewriting.
- R3: With fc3_ni = 1 (24-bit mode), an address matches when A23–A20 equal the effective slot. A31–A24 are ignored.
- R4: With fc3_ni = 0 (32-bit mode), an address matches when A31–A28 = $F and A27–A24 equal the effective slot. A23–A20 are ignored.
- R5: When fc_i (FC2..FC0) is 3'b111, no select is produced, whatever the address.
- R6: card_sel_no is the registered form of (as_ni low AND no CPU-space cycle AND address match AND host owns the bus). It goes low at the first rising edge that samples it true and goes high at the first edge that samples as_ni high. No select is produced while bgack_ni is low, or in the first cycle after bgack_ni returns high.
- R7: card_addr_o equals host_addr_i as sampled at the previous edge, with the active-mode slot nibble XORed with (slot XOR $E). All other bits are unchanged.
- R8: host_addr_o equals card_addr_i as sampled at the previous edge, with the same nibble XORed in the same way.
- R9: card_addr_oe_o is 1 only when bgack_ni was sampled high at the current and the previous edge. host_addr_oe_o is 1 only when bgack_ni was sampled low at both edges. The two are never 1 together, and both are 0 for one clock at every change of ownership.
- R10: slot_irq_no bit (slot − 9) follows card_irq_ni one clock later. Bit 0 is slot $9 and bit 5 is slot $E. All other bits stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_sel_i | input | 4 | Configured slot digit |
| host_addr_i | input | 32 | Host address bus |
| fc_i | input | 3 | Function codes FC2..FC0 |
| fc3_ni | input | 1 | Address mode: 1 = 24-bit, 0 = 32-bit |
| as_ni | input | 1 | Address strobe, active low |
| bgack_ni | input | 1 | Card owns the bus when low |
| card_addr_i | input | 32 | Address driven by the card while it masters |
| card_irq_ni | input | 1 | Card interrupt request, active low |
| card_sel_no | output | 1 | Card select, active low |
| card_addr_o | output | 32 | Rewritten address toward the card |
| host_addr_o | output | 32 | Rewritten address toward the host |
| card_addr_oe_o | output | 1 | Enable for the card-side address driver |
| host_addr_oe_o | output | 1 | Enable for the host-side address driver |
| slot_irq_no | output | 6 | Host slot interrupt lines $9..$E, active low |

## Verification
The following are checked on every cycle: the two driver enables never overlap, each enable rises only after the other has been low, CPU-space cycles and idle strobes never produce a select, a card-owned bus never produces a select, and at most one slot interrupt line is active. Only the bench scenarios can show that decoding and nibble rewriting are correct. These scenarios cover both address modes, every legal slot and the out-of-range settings, and they include addresses whose ignored nibbles take arbitrary values. The bench also shows the exact dead-cycle timing of an ownership handover and which interrupt line is chosen.

// File: rtl/slot_reloc_pkg.sv
package slot_reloc_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  typedef enum logic {MODE_32 = 1'b0, MODE_24 = 1'b1} amode_e;
endpackage

// File: rtl/slot_match.sv
module slot_match
  import slot_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NIB24_LSB = 20,
  parameter int unsigned NIB32_LSB = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  amode_e            mode_i,
  input  nib_t              slot_i,
  output logic              hit_o
);
  localparam int unsigned TOP_LSB = ADDR_W - NIB_W;

  always_comb begin
    if (mode_i == MODE_24) hit_o = (addr_i[NIB24_LSB +: NIB_W] == slot_i);
    else hit_o = (addr_i[TOP_LSB +: NIB_W] == '1) &&
                 (addr_i[NIB32_LSB +: NIB_W] == slot_i);
  end
endmodule

// File: rtl/slot_xlate.sv
module slot_xlate
  import slot_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NIB24_LSB = 20,
  parameter int unsigned NIB32_LSB = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  amode_e            mode_i,
  input  nib_t              mask_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = addr_i;
    if (mode_i == MODE_24) addr_o[NIB24_LSB +: NIB_W] = addr_i[NIB24_LSB +: NIB_W] ^ mask_i;
    else                   addr_o[NIB32_LSB +: NIB_W] = addr_i[NIB32_LSB +: NIB_W] ^ mask_i;
  end
endmodule

// File: rtl/bus_owner.sv
module bus_owner (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bgack_ni,
  output logic card_own_o,
  output logic card_oe_o,
  output logic host_oe_o
);
  logic own_q, card_oe_q, host_oe_q;

  // an enable needs two agreeing samples, giving a dead cycle on handover
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q     <= 1'b0;
      card_oe_q <= 1'b0;
      host_oe_q <= 1'b0;
    end else begin
      own_q     <= ~bgack_ni;
      card_oe_q <= ~own_q & bgack_ni;
      host_oe_q <= own_q & ~bgack_ni;
    end
  end

  assign card_own_o = own_q;
  assign card_oe_o  = card_oe_q;
  assign host_oe_o  = host_oe_q;
endmodule

// File: rtl/irq_route.sv
module irq_route
  import slot_reloc_pkg::*;
#(
  parameter int unsigned SLOT_LO   = 9,
  parameter int unsigned NUM_SLOTS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  nib_t                 slot_i,
  input  logic                 card_irq_ni,
  output logic [NUM_SLOTS-1:0] slot_irq_no
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_line
    localparam nib_t LINE_SLOT = nib_t'(SLOT_LO + i);
    logic irq_nq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_nq <= 1'b1;
      else         irq_nq <= (slot_i == LINE_SLOT) ? card_irq_ni : 1'b1;
    end
    assign slot_irq_no[i] = irq_nq;
  end
endmodule

// File: rtl/slot_relocator.sv
module slot_relocator
  import slot_reloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SLOT_LO   = 9,
  parameter int unsigned SLOT_HI   = 14,
  parameter int unsigned HOME_SLOT = 14,
  parameter int unsigned NUM_SLOTS = SLOT_HI - SLOT_LO + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [3:0]           slot_sel_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  input  logic [2:0]           fc_i,
  input  logic                 fc3_ni,
  input  logic                 as_ni,
  input  logic                 bgack_ni,
  input  logic [ADDR_W-1:0]    card_addr_i,
  input  logic                 card_irq_ni,
  output logic                 card_sel_no,
  output logic [ADDR_W-1:0]    card_addr_o,
  output logic [ADDR_W-1:0]    host_addr_o,
  output logic                 card_addr_oe_o,
  output logic                 host_addr_oe_o,
  output logic [NUM_SLOTS-1:0] slot_irq_no
);
  localparam int unsigned NIB24_LSB = 20;
  localparam int unsigned NIB32_LSB = 24;
  localparam nib_t SLOT_LO_N = nib_t'(SLOT_LO);
  localparam nib_t SLOT_HI_N = nib_t'(SLOT_HI);
  localparam nib_t HOME_N    = nib_t'(HOME_SLOT);

  nib_t        slot_q, mask;
  amode_e      mode;
  logic        hit, card_own, cpu_space, sel_q;
  logic [ADDR_W-1:0] to_card, to_host, card_addr_q, host_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= HOME_N;
    else if (slot_sel_i >= SLOT_LO_N && slot_sel_i <= SLOT_HI_N) slot_q <= slot_sel_i;
    else slot_q <= HOME_N;
  end

  assign mask      = slot_q ^ HOME_N;
  assign mode      = amode_e'(fc3_ni);
  assign cpu_space = &fc_i;

  slot_match #(.ADDR_W(ADDR_W), .NIB24_LSB(NIB24_LSB), .NIB32_LSB(NIB32_LSB)) u_match (
    .addr_i(host_addr_i), .mode_i(mode), .slot_i(slot_q), .hit_o(hit)
  );

  slot_xlate #(.ADDR_W(ADDR_W), .NIB24_LSB(NIB24_LSB), .NIB32_LSB(NIB32_LSB)) u_fwd (
    .addr_i(host_addr_i), .mode_i(mode), .mask_i(mask), .addr_o(to_card)
  );

  slot_xlate #(.ADDR_W(ADDR_W), .NIB24_LSB(NIB24_LSB), .NIB32_LSB(NIB32_LSB)) u_rev (
    .addr_i(card_addr_i), .mode_i(mode), .mask_i(mask), .addr_o(to_host)
  );

  bus_owner u_owner (
    .clk_i(clk_i), .rst_ni(rst_ni), .bgack_ni(bgack_ni),
    .card_own_o(card_own), .card_oe_o(card_addr_oe_o), .host_oe_o(host_addr_oe_o)
  );

  irq_route #(.SLOT_LO(SLOT_LO), .NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_q),
    .card_irq_ni(card_irq_ni), .slot_irq_no(slot_irq_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= 1'b0;
      card_addr_q <= '0;
      host_addr_q <= '0;
    end else begin
      sel_q       <= ~as_ni & ~cpu_space & hit & bgack_ni & ~card_own;
      card_addr_q <= to_card;
      host_addr_q <= to_host;
    end
  end

  assign card_sel_no = ~sel_q;
  assign card_addr_o = card_addr_q;
  assign host_addr_o = host_addr_q;
endmodule

// File: rtl/slot_relocator_chk.sv
module slot_relocator_chk #(
  parameter int unsigned NUM_SLOTS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           fc_i,
  input logic                 as_ni,
  input logic                 bgack_ni,
  input logic                 card_sel_no,
  input logic                 card_addr_oe_o,
  input logic                 host_addr_oe_o,
  input logic [NUM_SLOTS-1:0] slot_irq_no
);
  // R9
  oe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_addr_oe_o && host_addr_oe_o));

  // R9
  host_oe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_addr_oe_o) |-> !$past(card_addr_oe_o));

  // R9
  card_oe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_addr_oe_o) |-> !$past(host_addr_oe_o));

  // R5
  cpu_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&fc_i) |=> card_sel_no);

  // R6
  idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> card_sel_no);

  // R6
  card_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bgack_ni |=> card_sel_no);

  // R10
  one_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~slot_irq_no) <= 1);
endmodule

bind slot_relocator slot_relocator_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (.*);

// File: tb/slot_relocator_tb_top.sv
`timescale 1ns/1ps
module slot_relocator_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  slot_sel = 4'hE;
  logic [31:0] host_addr = '0, card_addr = '0;
  logic [2:0]  fc = 3'b001;
  logic        fc3_n = 1'b1, as_n = 1'b1, bgack_n = 1'b1, irq_n = 1'b1;
  logic        sel_n, c_oe, h_oe;
  logic [31:0] c_addr_o, h_addr_o;
  logic [5:0]  irq_o;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  slot_relocator dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .slot_sel_i(slot_sel), .host_addr_i(host_addr),
    .fc_i(fc), .fc3_ni(fc3_n), .as_ni(as_n), .bgack_ni(bgack_n),
    .card_addr_i(card_addr), .card_irq_ni(irq_n), .card_sel_no(sel_n),
    .card_addr_o(c_addr_o), .host_addr_o(h_addr_o), .card_addr_oe_o(c_oe),
    .host_addr_oe_o(h_oe), .slot_irq_no(irq_o)
  );

  function automatic logic [3:0] eff(input logic [3:0] s);
    return (s >= 4'h9 && s <= 4'hE) ? s : 4'hE;
  endfunction

  function automatic logic exp_hit(input logic [31:0] a, input logic m24, input logic [3:0] s);
    if (m24) return a[23:20] == eff(s);
    return a[31:28] == 4'hF && a[27:24] == eff(s);
  endfunction

  function automatic logic [31:0] exp_xl(input logic [31:0] a, input logic m24, input logic [3:0] s);
    logic [31:0] r = a;
    logic [3:0]  m = eff(s) ^ 4'hE;
    if (m24) r[23:20] = a[23:20] ^ m;
    else     r[27:24] = a[27:24] ^ m;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_slot(input logic [3:0] s);
    slot_sel = s;
    tick(3);
  endtask

  task automatic rand_phase(input logic [3:0] s, input int n);
    string tag;
    for (int i = 0; i < n; i++) begin
      logic m24 = $urandom_range(0, 1) == 1;
      logic [31:0] a = $urandom();
      logic want_sel;
      if ($urandom_range(0, 1) == 1) begin
        if (m24) a[23:20] = eff(s);
        else begin a[31:28] = 4'hF; a[27:24] = eff(s); end
      end
      fc3_n = m24; host_addr = a;
      fc = ($urandom_range(0, 7) == 0) ? 3'b111 : 3'($urandom_range(0, 6));
      as_n = $urandom_range(0, 4) == 0;
      want_sel = !as_n && (fc != 3'b111) && exp_hit(a, m24, s);
      tick(1);
      tag = (s < 4'h9 || s > 4'hE) ? "R2" : (fc == 3'b111) ? "R5" : m24 ? "R3" : "R4";
      chk({tag, " select"}, {31'd0, sel_n}, {31'd0, !want_sel});
      chk("R7 card addr", c_addr_o, exp_xl(a, m24, s));
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [3:0] cfgs [8] = '{4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF, 4'h0};
    void'($urandom(32'h5EED_1234));
    tick(3);
    // R1 reset state
    chk("R1 sel", {31'd0, sel_n}, 32'd1);
    chk("R1 oe", {30'd0, c_oe, h_oe}, 32'd0);
    chk("R1 irq", {26'd0, irq_o}, 32'h3F);
    rst_ni = 1'b1;
    tick(2);
    // R1 default slot $E: 24-bit $E access passes through unchanged
    host_addr = 32'h00E1_2345; fc3_n = 1'b1; as_n = 1'b0; tick(1);
    chk("R1 default slot", {31'd0, sel_n}, 32'd0);
    chk("R1 passthrough", c_addr_o, 32'h00E1_2345);
    as_n = 1'b1; tick(1);
    chk("R6 deassert", {31'd0, sel_n}, 32'd1);

    // directed: slot $A, 24-bit and 32-bit with ssx form
    set_slot(4'hA);
    host_addr = 32'h12A5_4321; fc3_n = 1'b1; as_n = 1'b0; tick(1);
    chk("R3 hit A", {31'd0, sel_n}, 32'd0);
    chk("R7 A->E", c_addr_o, 32'h12E5_4321);
    host_addr = 32'hFAA0_0010; fc3_n = 1'b0; tick(1);
    chk("R4 hit ssx", {31'd0, sel_n}, 32'd0);
    chk("R7 32 A->E", c_addr_o, 32'hFEA0_0010);
    host_addr = 32'h7A00_0010; tick(1);
    chk("R4 top nibble", {31'd0, sel_n}, 32'd1);
    host_addr = 32'hFA00_0010; fc = 3'b111; tick(1);
    chk("R5 cpu space", {31'd0, sel_n}, 32'd1);
    fc = 3'b001; as_n = 1'b1; tick(1);

    // R9/R8/R6 ownership handover
    fc3_n = 1'b1; card_addr = 32'h00E0_0100;
    host_addr = 32'h00A0_0000; as_n = 1'b0; bgack_n = 1'b0; tick(1);
    chk("R9 gap to card", {30'd0, c_oe, h_oe}, 32'd0);
    chk("R6 no sel owned", {31'd0, sel_n}, 32'd1);
    chk("R8 host addr", h_addr_o, 32'h00A0_0100);
    tick(1);
    chk("R9 host oe", {30'd0, c_oe, h_oe}, 32'd1);
    chk("R6 no sel owned", {31'd0, sel_n}, 32'd1);
    bgack_n = 1'b1; tick(1);
    chk("R9 gap to host", {30'd0, c_oe, h_oe}, 32'd0);
    chk("R6 no sel returning", {31'd0, sel_n}, 32'd1);
    tick(1);
    chk("R9 card oe", {30'd0, c_oe, h_oe}, 32'd2);
    chk("R6 sel resumes", {31'd0, sel_n}, 32'd0);
    as_n = 1'b1; tick(1);

    // R10 interrupt routing
    for (int k = 0; k < 8; k++) begin
      set_slot(cfgs[k]);
      irq_n = 1'b0; tick(1);
      chk("R10 irq line", {26'd0, irq_o}, {26'd0, ~(6'd1 << (eff(cfgs[k]) - 4'h9))});
      irq_n = 1'b1; tick(1);
      chk("R10 irq idle", {26'd0, irq_o}, 32'h3F);
    end

    // R2..R7 random per configuration
    for (int k = 0; k < 8; k++) begin
      set_slot(cfgs[k]);
      rand_phase(cfgs[k], 300);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule